// File: doc/BRIEF.md
# Multi-Mode DMA Arbiter and Address Generator

This block shares one 16-bit internal memory port among several DMA clients. The default build has three: a video client that moves image data at a fixed rate, a processor data-memory client and a host-buffer client. Each client holds a request line high together with a descriptor. The descriptor gives a priority level, an addressing mode, a direction, a start word address, a word count and the geometry fields the mode needs. The block picks one request, pulses a one-cycle grant back to that client and then issues one word address with enable and write strobes on every cycle until the count is used up. It ends the transfer with a one-cycle done pulse to the client.

The control is a three-state machine. `ST_IDLE` arbitrates, and the transition take-grant (some request pending) leads to `ST_BURST`. `ST_BURST` drives one word per cycle, and the transition last-word (word counter at zero) leads to `ST_FINISH`. `ST_FINISH` pulses done, and the transition always-return leads back to `ST_IDLE`. A burst is never cut short. There is at least one idle cycle between bursts, and the next decision is taken in that cycle.

Requests are not queued. A client keeps its request and descriptor steady until it sees its grant, and it then lowers the request. Addresses are 16-bit word addresses.

Top module: `mdma_engine`

## Requirements
- R1: While reset is held, and after it is released with no request pending, mem_en, mem_we, gnt and done are all low.
- R2: Client 0 (video) always competes at level 0 and has no level input. When it is pending in the arbitration cycle, it is granted before any other client.
- R3: Every other client k has a 2-bit level field at req_lvl[2(k-1)+:2]. A lower value wins, and the value 0 is served as level 1.
- R4: Among pending clients at the best level, the search starts at the client after the last one granted and wraps around. After reset, the last granted client counts as client NCLI-1.
- R5: gnt is one-hot and lasts exactly one cycle, the first word cycle of the burst. A burst runs to the end without interruption, whatever requests arrive meanwhile.
- R6: The count field req_cnt holds the number of words minus one, so 8 bits cover 1 to 256 words. The words are issued on consecutive cycles.
- R7: Mode code 0 (linear): the address starts at req_addr and rises by one per word.
- R8: Mode code 1 (matrix): rows are req_rowlen words long, and each row starts req_stride words after the start of the previous row.
- R9: Mode code 2 (ring): the address starts at req_addr and rises by one. After the word at req_ring_hi, the next word is at req_ring_lo.
- R10: Mode code 3 (ring with offset): the first address is req_addr plus req_ofs. If this sum is above req_ring_hi, the ring size (hi-lo+1) is subtracted from it. The walk then continues as in ring mode. The offset must be smaller than the ring size.
- R11: done pulses for one cycle on the owning client's bit, in the cycle right after the last word. mem_en is low in that cycle.
- R12: mem_we equals the granted client's req_wr bit and holds that value for every word of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NCLI | Request line per client, bit 0 is video |
| req_lvl | input | 2*(NCLI-1) | Priority level of clients 1 and up |
| req_mode | input | 2*NCLI | Addressing mode code per client |
| req_wr | input | NCLI | Direction per client, 1 = write |
| req_addr | input | AW*NCLI | Start word address per client |
| req_cnt | input | CW*NCLI | Word count minus one per client |
| req_rowlen | input | LW*NCLI | Matrix row length in words |
| req_stride | input | AW*NCLI | Matrix row stride in words |
| req_ring_lo | input | AW*NCLI | Ring first address |
| req_ring_hi | input | AW*NCLI | Ring last address |
| req_ofs | input | AW*NCLI | Start offset for mode 3 |
| gnt | output | NCLI | One-cycle grant pulse, one-hot |
| done | output | NCLI | One-cycle completion pulse, one-hot |
| mem_en | output | 1 | Memory word strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |

## Verification
The bench builds the block with three clients, a 12-bit address, an 8-bit count and an 8-bit row length. At these values the full 256-word burst runs to its end inside the address space, and both ring wrap and offset wrap fit in small windows that can be checked word by word. With three clients, a priority win, a round-robin tie in either order, the clamp of level 0 and a video request that arrives during another burst can each be set up in a few transfers. The scoreboard predicts every word's address and direction from the requirements and compares them in the order the words appear.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    typedef enum logic [1:0] {
        AM_LINEAR   = 2'd0,
        AM_MATRIX   = 2'd1,
        AM_RING     = 2'd2,
        AM_RING_OFS = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BURST  = 2'd1,
        ST_FINISH = 2'd2
    } dma_state_e;

    localparam int unsigned LVL_W = 2;

endpackage

// File: rtl/mdma_arbiter.sv
module mdma_arbiter #(
    parameter int unsigned NCLI = 3,
    localparam int unsigned IW  = (NCLI > 1) ? $clog2(NCLI) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NCLI-1:0]                   req,
    input  logic [mdma_pkg::LVL_W*(NCLI-1)-1:0] lvl,
    input  logic                              take,
    output logic                              any,
    output logic [IW-1:0]                     win_idx
);
    import mdma_pkg::*;

    logic [LVL_W-1:0] eff_lvl [NCLI];
    logic [LVL_W-1:0] best;
    logic [IW-1:0]    last_q;
    logic             found;

    // Effective level: video fixed at 0, others clamped to 1..3
    generate
        for (genvar g = 0; g < NCLI; g++) begin : g_lvl
            if (g == 0) begin : g_vid
                assign eff_lvl[g] = '0;
            end else begin : g_oth
                assign eff_lvl[g] = (lvl[LVL_W*(g-1) +: LVL_W] == '0)
                                    ? LVL_W'(1) : lvl[LVL_W*(g-1) +: LVL_W];
            end
        end
    endgenerate

    always_comb begin
        best = '1;
        for (int k = 0; k < NCLI; k++) begin
            if (req[k] && (eff_lvl[k] < best)) begin
                best = eff_lvl[k];
            end
        end
    end

    assign any = |req;

    // Round-robin search among the best level, starting after last grant
    always_comb begin
        int j;
        found   = 1'b0;
        win_idx = '0;
        j       = 0;
        for (int i = 1; i <= NCLI; i++) begin
            j = int'(last_q) + i;
            if (j >= NCLI) begin
                j = j - NCLI;
            end
            if (!found && req[j] && (eff_lvl[j] == best)) begin
                found   = 1'b1;
                win_idx = j[IW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IW'(NCLI - 1);
        end else if (take && found) begin
            last_q <= win_idx;
        end
    end

endmodule

// File: rtl/mdma_addr_gen.sv
module mdma_addr_gen #(
    parameter int unsigned AW = 16,
    parameter int unsigned LW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  mdma_pkg::addr_mode_e mode,
    input  logic [AW-1:0]        start,
    input  logic [LW-1:0]        rowlen,
    input  logic [AW-1:0]        stride,
    input  logic [AW-1:0]        ring_lo,
    input  logic [AW-1:0]        ring_hi,
    input  logic [AW-1:0]        ofs,
    output logic [AW-1:0]        addr
);
    import mdma_pkg::*;

    addr_mode_e    mode_q;
    logic [AW-1:0] addr_q, stride_q, lo_q, hi_q;
    logic [LW-1:0] rowlen_q, col_q;
    logic [AW-1:0] sum, span, first, nxt;
    logic          row_end;

    // Start address, including the per-transfer offset of mode 3
    always_comb begin
        sum  = start + ofs;
        span = ring_hi - ring_lo + AW'(1);
        if (mode == AM_RING_OFS) begin
            first = (sum > ring_hi) ? (sum - span) : sum;
        end else begin
            first = start;
        end
    end

    assign row_end = (col_q == (rowlen_q - LW'(1)));

    always_comb begin
        unique case (mode_q)
            AM_LINEAR: nxt = addr_q + AW'(1);
            AM_MATRIX: nxt = row_end ? (addr_q + stride_q - AW'(rowlen_q) + AW'(1))
                                     : (addr_q + AW'(1));
            AM_RING,
            AM_RING_OFS: nxt = (addr_q == hi_q) ? lo_q : (addr_q + AW'(1));
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= AM_LINEAR;
            addr_q   <= '0;
            stride_q <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            rowlen_q <= '0;
            col_q    <= '0;
        end else if (load) begin
            mode_q   <= mode;
            addr_q   <= first;
            stride_q <= stride;
            lo_q     <= ring_lo;
            hi_q     <= ring_hi;
            rowlen_q <= rowlen;
            col_q    <= '0;
        end else if (step) begin
            addr_q <= nxt;
            col_q  <= row_end ? '0 : (col_q + LW'(1));
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/mdma_word_ctr.sv
module mdma_word_ctr #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] cnt_in,
    input  logic          step,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= cnt_in;
        end else if (step && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/mdma_engine.sv
module mdma_engine #(
    parameter int unsigned NCLI = 3,
    parameter int unsigned AW   = 16,
    parameter int unsigned CW   = 8,
    parameter int unsigned LW   = 8,
    localparam int unsigned IW  = (NCLI > 1) ? $clog2(NCLI) : 1,
    localparam int unsigned LVW = mdma_pkg::LVL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCLI-1:0]           req,
    input  logic [LVW*(NCLI-1)-1:0]   req_lvl,
    input  logic [2*NCLI-1:0]         req_mode,
    input  logic [NCLI-1:0]           req_wr,
    input  logic [AW*NCLI-1:0]        req_addr,
    input  logic [CW*NCLI-1:0]        req_cnt,
    input  logic [LW*NCLI-1:0]        req_rowlen,
    input  logic [AW*NCLI-1:0]        req_stride,
    input  logic [AW*NCLI-1:0]        req_ring_lo,
    input  logic [AW*NCLI-1:0]        req_ring_hi,
    input  logic [AW*NCLI-1:0]        req_ofs,
    output logic [NCLI-1:0]           gnt,
    output logic [NCLI-1:0]           done,
    output logic                      mem_en,
    output logic                      mem_we,
    output logic [AW-1:0]             mem_addr
);
    import mdma_pkg::*;

    dma_state_e    state_q, state_d;
    logic [IW-1:0] owner_q, win_idx;
    logic          we_q, first_q;
    logic          arb_any, take, last_word, step;
    logic [AW-1:0] ag_addr;

    addr_mode_e    sel_mode;
    logic [AW-1:0] sel_addr, sel_stride, sel_lo, sel_hi, sel_ofs;
    logic [CW-1:0] sel_cnt;
    logic [LW-1:0] sel_rowlen;

    assign take = (state_q == ST_IDLE) && arb_any;
    assign step = (state_q == ST_BURST);

    mdma_arbiter #(.NCLI(NCLI)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .lvl     (req_lvl),
        .take    (take),
        .any     (arb_any),
        .win_idx (win_idx)
    );

    // Descriptor of the winning client
    always_comb begin
        sel_mode   = addr_mode_e'(req_mode[2*win_idx +: 2]);
        sel_addr   = req_addr[AW*win_idx +: AW];
        sel_cnt    = req_cnt[CW*win_idx +: CW];
        sel_rowlen = req_rowlen[LW*win_idx +: LW];
        sel_stride = req_stride[AW*win_idx +: AW];
        sel_lo     = req_ring_lo[AW*win_idx +: AW];
        sel_hi     = req_ring_hi[AW*win_idx +: AW];
        sel_ofs    = req_ofs[AW*win_idx +: AW];
    end

    mdma_addr_gen #(.AW(AW), .LW(LW)) u_agen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take),
        .step    (step),
        .mode    (sel_mode),
        .start   (sel_addr),
        .rowlen  (sel_rowlen),
        .stride  (sel_stride),
        .ring_lo (sel_lo),
        .ring_hi (sel_hi),
        .ofs     (sel_ofs),
        .addr    (ag_addr)
    );

    mdma_word_ctr #(.CW(CW)) u_wctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (take),
        .cnt_in (sel_cnt),
        .step   (step),
        .last   (last_word)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (arb_any)   state_d = ST_BURST;
            ST_BURST:  if (last_word) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and per-burst context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            we_q    <= 1'b0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                owner_q <= win_idx;
                we_q    <= req_wr[win_idx];
                first_q <= 1'b1;
            end else if (step) begin
                first_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_en   = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        gnt      = '0;
        done     = '0;
        unique case (state_q)
            ST_BURST: begin
                mem_en   = 1'b1;
                mem_we   = we_q;
                mem_addr = ag_addr;
                for (int k = 0; k < NCLI; k++) begin
                    gnt[k] = first_q && (owner_q == IW'(k));
                end
            end
            ST_FINISH: begin
                for (int k = 0; k < NCLI; k++) begin
                    done[k] = (owner_q == IW'(k));
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mdma_checker.sv
module mdma_checker #(
    parameter int unsigned NCLI = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCLI-1:0] req,
    input logic [NCLI-1:0] gnt,
    input logic [NCLI-1:0] done,
    input logic            mem_en,
    input logic            mem_we
);

    p_gnt_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_gnt_opens_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> (mem_en && !$past(mem_en)));

    p_gnt_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> !(|gnt));

    p_video_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt[NCLI-1:1]) |-> !$past(req[0]));

    p_done_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    p_done_after_words_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |-> (!mem_en && $past(mem_en)));

    p_dir_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(mem_en)) |-> $stable(mem_we));

    p_quiet_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_en && !(|gnt) && !(|done)) || !rst_n);

endmodule

bind mdma_engine mdma_checker #(.NCLI(NCLI)) u_mdma_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .gnt    (gnt),
    .done   (done),
    .mem_en (mem_en),
    .mem_we (mem_we)
);

// File: tb/mdma_engine_bench.sv
module mdma_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCLI = 3;
    localparam int AW   = 12;
    localparam int CW   = 8;
    localparam int LW   = 8;

    typedef struct {
        logic          we;
        logic [AW-1:0] a;
        string         rq;
    } word_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NCLI-1:0]       req = '0;
    logic [2*(NCLI-1)-1:0] req_lvl = '0;
    logic [2*NCLI-1:0]     req_mode = '0;
    logic [NCLI-1:0]       req_wr = '0;
    logic [AW*NCLI-1:0]    req_addr = '0;
    logic [CW*NCLI-1:0]    req_cnt = '0;
    logic [LW*NCLI-1:0]    req_rowlen = '0;
    logic [AW*NCLI-1:0]    req_stride = '0;
    logic [AW*NCLI-1:0]    req_ring_lo = '0;
    logic [AW*NCLI-1:0]    req_ring_hi = '0;
    logic [AW*NCLI-1:0]    req_ofs = '0;
    logic [NCLI-1:0]       gnt, done;
    logic                  mem_en, mem_we;
    logic [AW-1:0]         mem_addr;

    word_t exp_q[$];
    int    exp_ord[$];
    int    got_ord[$];
    int    checks = 0, errors = 0;
    int    mon_checks = 0, mon_errs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdma_engine #(.NCLI(NCLI), .AW(AW), .CW(CW), .LW(LW)) u_mdma_engine (
        .clk(clk), .rst_n(rst_n), .req(req), .req_lvl(req_lvl),
        .req_mode(req_mode), .req_wr(req_wr), .req_addr(req_addr),
        .req_cnt(req_cnt), .req_rowlen(req_rowlen), .req_stride(req_stride),
        .req_ring_lo(req_ring_lo), .req_ring_hi(req_ring_hi), .req_ofs(req_ofs),
        .gnt(gnt), .done(done), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr)
    );

    // Monitor: compare every issued word against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && mem_en) begin
            mon_checks++;
            if (exp_q.size() == 0) begin
                mon_errs++;
                $display("FAIL R6 unexpected word addr=%h expected none", mem_addr);
            end else begin
                word_t w;
                w = exp_q.pop_front();
                if (mem_addr !== w.a) begin
                    mon_errs++;
                    $display("FAIL %s addr=%h expected %h", w.rq, mem_addr, w.a);
                end else if (mem_we !== w.we) begin
                    mon_errs++;
                    $display("FAIL R12 we=%b expected %b at %h", mem_we, w.we, w.a);
                end
            end
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    // Driver: load a descriptor and push the words it must produce
    task automatic xfer(input int c, input int lv, input int md, input bit w,
                        input int a, input int n, input int rl, input int st,
                        input int lo, input int hi, input int ofs, input string rq);
        int cur, col, t;
        word_t item;
        if (c > 0) begin
            t = lv; req_lvl[2*(c-1) +: 2] = t[1:0];
        end
        t = md;  req_mode[2*c +: 2]       = t[1:0];
        req_wr[c] = w;
        t = a;   req_addr[AW*c +: AW]     = t[AW-1:0];
        t = n-1; req_cnt[CW*c +: CW]      = t[CW-1:0];
        t = rl;  req_rowlen[LW*c +: LW]   = t[LW-1:0];
        t = st;  req_stride[AW*c +: AW]   = t[AW-1:0];
        t = lo;  req_ring_lo[AW*c +: AW]  = t[AW-1:0];
        t = hi;  req_ring_hi[AW*c +: AW]  = t[AW-1:0];
        t = ofs; req_ofs[AW*c +: AW]      = t[AW-1:0];
        cur = a;
        if (md == 3) begin
            cur = a + ofs;
            if (cur > hi) cur = cur - (hi - lo + 1);
        end
        col = 0;
        for (int i = 0; i < n; i++) begin
            item.we = w; item.a = cur[AW-1:0]; item.rq = rq;
            exp_q.push_back(item);
            case (md)
                0: cur++;
                1: if (col == rl - 1) begin cur = cur - (rl - 1) + st; col = 0; end
                   else begin cur++; col++; end
                default: cur = (cur == hi) ? lo : cur + 1;
            endcase
        end
        exp_ord.push_back(c);
    endtask

    // Raise requests, drop each on its grant, collect done order
    task automatic run(input logic [NCLI-1:0] mask, input logic [NCLI-1:0] late,
                       input string rq);
        int  cyc;
        bit  prev_en, late_done;
        cyc = 0; prev_en = 0; late_done = 0;
        got_ord.delete();
        @(negedge clk);
        req = mask;
        while (got_ord.size() < exp_ord.size() && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            for (int k = 0; k < NCLI; k++) begin
                if (gnt[k]) begin
                    req[k] = 1'b0;
                    if (late != '0 && !late_done) begin
                        req = req | late;
                        late_done = 1;
                    end
                end
            end
            for (int k = 0; k < NCLI; k++) begin
                if (done[k]) begin
                    got_ord.push_back(k);
                    // R11: done right after the last word, no word with it
                    check(prev_en && !mem_en, "R11", int'(mem_en), 0);
                end
            end
            prev_en = mem_en;
        end
        check(cyc < 3000, {rq, " watchdog"}, cyc, 3000);
        check(got_ord == exp_ord, {rq, " order"},
              got_ord.size() > 0 ? got_ord[0] : -1,
              exp_ord.size() > 0 ? exp_ord[0] : -1);
        check(exp_q.size() == 0, {rq, " words left"}, exp_q.size(), 0);
        exp_ord.delete();
        exp_q.delete();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=150000 expected<150000");
        $display("  CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errs + 1);
        $finish;
    end

    initial begin
        // R1: quiet under reset even with requests pending
        req = '1;
        repeat (3) @(negedge clk);
        check(mem_en === 1'b0, "R1 mem_en", int'(mem_en), 0);
        check(gnt === '0, "R1 gnt", int'(gnt), 0);
        check(done === '0, "R1 done", int'(done), 0);
        req = '0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!mem_en && gnt === '0 && done === '0 && !mem_we, "R1 idle",
              int'(mem_en), 0);

        // R7 linear, write: 100..103
        xfer(1, 1, 0, 1'b1, 'h100, 4, 1, 0, 0, 0, 0, "R7");
        run(3'b010, 3'b000, "R7");

        // R8 matrix rows of 3, stride 16: 200,201,202,210,211,212
        xfer(2, 1, 1, 1'b0, 'h200, 6, 3, 16, 0, 0, 0, "R8");
        run(3'b100, 3'b000, "R8");

        // R9 ring 40..43 from 42: 42,43,40,41,42,43
        xfer(1, 1, 2, 1'b0, 'h42, 6, 1, 0, 'h40, 'h43, 0, "R9");
        run(3'b010, 3'b000, "R9");

        // R10 offset wraps: 45+5=4A -> 42: 42,43,44
        xfer(2, 1, 3, 1'b1, 'h45, 3, 1, 0, 'h40, 'h47, 5, "R10");
        run(3'b100, 3'b000, "R10 wrap");
        // R10 offset without wrap: 41+2=43: 43,44
        xfer(2, 1, 3, 1'b0, 'h41, 2, 1, 0, 'h40, 'h47, 2, "R10");
        run(3'b100, 3'b000, "R10 plain");

        // R6 longest burst: 256 words 300..3FF on the video client
        xfer(0, 0, 0, 1'b1, 'h300, 256, 1, 0, 0, 0, 0, "R6");
        run(3'b001, 3'b000, "R6");

        // R2 video first although others request; R4 then 1 before 2 (last=0)
        xfer(0, 0, 0, 1'b0, 'h010, 2, 1, 0, 0, 0, 0, "R2");
        xfer(1, 1, 0, 1'b1, 'h020, 2, 1, 0, 0, 0, 0, "R4");
        xfer(2, 1, 0, 1'b0, 'h030, 2, 1, 0, 0, 0, 0, "R4");
        run(3'b111, 3'b000, "R2");

        // R4: client 1 alone (last=1), then tie at level 3 -> 2 before 1
        xfer(1, 3, 0, 1'b0, 'h050, 1, 1, 0, 0, 0, 0, "R4");
        run(3'b010, 3'b000, "R4 setup");
        xfer(2, 3, 0, 1'b0, 'h060, 2, 1, 0, 0, 0, 0, "R4");
        xfer(1, 3, 0, 1'b1, 'h070, 2, 1, 0, 0, 0, 0, "R4");
        run(3'b110, 3'b000, "R4 rr");

        // R3: last=1 so a tie would pick 2; level 2 beats level 3 -> 1 first
        xfer(1, 2, 0, 1'b0, 'h080, 2, 1, 0, 0, 0, 0, "R3");
        xfer(2, 3, 0, 1'b0, 'h090, 2, 1, 0, 0, 0, 0, "R3");
        run(3'b110, 3'b000, "R3 level");

        // R3: level 0 on client 1 acts as level 1; with last=1, 2 goes first
        xfer(1, 1, 0, 1'b0, 'h0A0, 1, 1, 0, 0, 0, 0, "R3");
        run(3'b010, 3'b000, "R3 setup");
        xfer(2, 1, 0, 1'b1, 'h0B0, 2, 1, 0, 0, 0, 0, "R3");
        xfer(1, 0, 0, 1'b0, 'h0C0, 2, 1, 0, 0, 0, 0, "R3");
        run(3'b110, 3'b000, "R3 clamp");

        // R5: video raised during an 8-word burst waits for its end
        xfer(1, 1, 0, 1'b1, 'h500, 8, 1, 0, 0, 0, 0, "R5");
        xfer(0, 0, 0, 1'b0, 'h600, 2, 1, 0, 0, 0, 0, "R5");
        run(3'b010, 3'b001, "R5");

        repeat (4) @(negedge clk);
        check(!mem_en && gnt === '0, "R1 idle at end", int'(mem_en), 0);

        $display("  CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
        $finish;
    end

endmodule